// File: doc/BRIEF.md
# Resumable Repeat-Move Sequencer

This block is the execution engine behind a repeat instruction that applies to a single memory-to-memory word move. The number of iterations is never encoded in the repeat instruction. It comes from an architectural count register that an earlier, separate instruction writes. Each iteration reads one word at the source pointer and writes that word at the destination pointer. Both pointers then advance by one and the count drops by one.

All progress of a copy is held in visible registers: the count, the two pointers and the address of the repeat instruction. Because of this, an interrupt can be taken at any boundary between iterations without waiting for the copy to finish. When an interrupt is taken, the block reports the repeat instruction's own address as the return address. Executing the repeat instruction again later performs only the moves that remain. When the count runs out, the block pulses completion and reports the address two slots further on, which skips the repeat op and the move that follows it.

The interrupt controller and the stack push sit outside this block. They see a one-cycle take pulse together with the return address.

Top module: `rep_move_seq`

## Requirements
- R1: After a synchronous reset the block is idle: busy, mem_req, done and irq_take are low, and the count and both pointers read zero.
- R2: The count register and the two pointers load from their write inputs only while the block is idle. Writes presented while busy is high leave all three unchanged, and go is ignored while busy.
- R3: An iteration reads the word at the source pointer and then writes that same data at the destination pointer. When the write is accepted, the count decreases by one and both pointers increase by one, wrapping at their width.
- R4: A memory request with mem_req high holds its address, direction and write data until a cycle in which mem_ready is high.
- R5: If the count is zero when go is accepted, done pulses in the next cycle, no memory request is made, and ret_pc equals op_pc + 2.
- R6: done is a one-cycle pulse raised at the first boundary where the count is zero. In that cycle ret_pc equals op_pc + 2, and busy is low in the next cycle.
- R7: When irq_req is high at a boundary and the count is non-zero, irq_take pulses for one cycle with ret_pc equal to op_pc. The block goes idle and keeps the remaining count and the current pointers.
- R8: An interrupt raised during the read or the write of an iteration is not taken until that iteration's write has been accepted. It is taken at that next boundary and is not held off until the copy finishes.
- R9: An interrupted copy that is resumed by issuing go again with the same op_pc leaves memory identical to an uninterrupted forward copy, including when the destination region overlaps the source region.
- R10: At a boundary where the count is zero, completion wins: done pulses, and irq_take stays low even while irq_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr | input | 1 | Write the count register (idle only) |
| cnt_din | input | CW | New count value |
| ptr_wr | input | 1 | Write both pointers (idle only) |
| src_din | input | AW | New source pointer |
| dst_din | input | AW | New destination pointer |
| go | input | 1 | Repeat instruction issued |
| op_pc | input | PW | Address of the repeat instruction |
| irq_req | input | 1 | Pending interrupt |
| irq_take | output | 1 | Interrupt accepted at this boundary |
| done | output | 1 | Count exhausted, repeat complete |
| ret_pc | output | PW | Resume address, valid with done or irq_take |
| busy | output | 1 | Repeat in progress |
| cnt_q | output | CW | Count register |
| src_q | output | AW | Source pointer |
| dst_q | output | AW | Destination pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory accepts the request |

## Verification
The bench splits a copy with an interrupt raised in the middle of a read that is stalled by the memory. A design that kept the counter-load address, or the move address, as the return address would leave memory off by iterations against a forward-copy golden image. So would a design that committed the pointers before the write. The overlapping case, with the destination two words ahead of the source, shows whether resumption replays moves: a replay would copy already-propagated data one more time. A zero count checks that no stray read occurs, and a zero count with an interrupt held high checks that completion beats the take. Pointer and count writes during a copy check that the architectural state cannot be corrupted while busy.

// File: rtl/rep_move_pkg.sv
package rep_move_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BOUND = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } rm_phase_e;

    // the move instruction follows the repeat op; completion skips both
    localparam int unsigned RM_SKIP = 2;

    function automatic logic [31:0] rm_resume(input logic [31:0] pc, input logic fin);
        return fin ? pc + RM_SKIP : pc;
    endfunction

endpackage

// File: rtl/rm_arch_regs.sv
module rm_arch_regs #(
    parameter int CW = 8,
    parameter int AW = 8,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_din,
    input  logic          ptr_wr,
    input  logic [AW-1:0] src_din,
    input  logic [AW-1:0] dst_din,
    input  logic          go,
    input  logic [PW-1:0] op_pc,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [PW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            src <= '0;
            dst <= '0;
            pc  <= '0;
        end else if (idle) begin
            if (cnt_wr) cnt <= cnt_din;
            if (ptr_wr) begin
                src <= src_din;
                dst <= dst_din;
            end
            if (go) pc <= op_pc;
        end else if (step) begin
            cnt <= cnt - CW'(1);
            src <= src + AW'(1);
            dst <= dst + AW'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt == $past(cnt) - CW'(1)); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (src == $past(src) + AW'(1)) && (dst == $past(dst) + AW'(1))); // R3
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!idle && !step) |=> $stable(cnt) && $stable(src) && $stable(dst)); // R2

endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
    import rep_move_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          irq_req,
    input  logic          cnt_zero,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          idle,
    output logic          step,
    output logic          fin,
    output logic          take,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    rm_phase_e ph;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            hold_q <= '0;
        end else begin
            unique case (ph)
                PH_IDLE:  if (go) ph <= PH_BOUND;
                PH_BOUND: begin
                    if (cnt_zero || irq_req) ph <= PH_IDLE;
                    else                     ph <= PH_READ;
                end
                PH_READ: if (mem_ready) begin
                    hold_q <= mem_rdata;
                    ph     <= PH_WRITE;
                end
                PH_WRITE: if (mem_ready) ph <= PH_BOUND;
                default:  ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        idle      = (ph == PH_IDLE);
        fin       = (ph == PH_BOUND) && cnt_zero;
        take      = (ph == PH_BOUND) && !cnt_zero && irq_req;
        mem_req   = (ph == PH_READ) || (ph == PH_WRITE);
        mem_we    = (ph == PH_WRITE);
        mem_addr  = mem_we ? dst : src;
        mem_wdata = hold_q;
        step      = (ph == PH_WRITE) && mem_ready;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R4
    AST_TAKE_IDLES: assert property (@(posedge clk) disable iff (rst)
        take |=> idle); // R7
    AST_FIN_IDLES: assert property (@(posedge clk) disable iff (rst)
        fin |=> idle); // R6
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> mem_req && mem_we); // R8
    AST_ONE_EXIT: assert property (@(posedge clk) disable iff (rst)
        !(fin && take)); // R10

endmodule

// File: rtl/rep_move_seq.sv
module rep_move_seq
    import rep_move_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int CW = 8,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_din,
    input  logic          ptr_wr,
    input  logic [AW-1:0] src_din,
    input  logic [AW-1:0] dst_din,
    input  logic          go,
    input  logic [PW-1:0] op_pc,
    input  logic          irq_req,
    output logic          irq_take,
    output logic          done,
    output logic [PW-1:0] ret_pc,
    output logic          busy,
    output logic [CW-1:0] cnt_q,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    logic          idle, step, fin, take;
    logic [PW-1:0] pc;
    logic [31:0]   pc_wide;

    rm_arch_regs #(.CW(CW), .AW(AW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .idle    (idle),
        .cnt_wr  (cnt_wr),
        .cnt_din (cnt_din),
        .ptr_wr  (ptr_wr),
        .src_din (src_din),
        .dst_din (dst_din),
        .go      (go),
        .op_pc   (op_pc),
        .step    (step),
        .cnt     (cnt_q),
        .src     (src_q),
        .dst     (dst_q),
        .pc      (pc)
    );

    rm_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .irq_req   (irq_req),
        .cnt_zero  (cnt_q == '0),
        .src       (src_q),
        .dst       (dst_q),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .idle      (idle),
        .step      (step),
        .fin       (fin),
        .take      (take),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign pc_wide  = rm_resume(32'(pc), fin);
    assign ret_pc   = pc_wide[PW-1:0];
    assign busy     = !idle;
    assign done     = fin;
    assign irq_take = take;

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> cnt_q == '0); // R6
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R1

endmodule

// File: tb/sim_rep_move_seq.sv
module sim_rep_move_seq;
    localparam int AW = 8, DW = 16, CW = 8, PW = 12;
    localparam int MSZ = 1 << AW;

    logic clk = 0, rst = 1;
    logic cnt_wr = 0, ptr_wr = 0, go = 0, irq_req = 0, mem_ready = 1;
    logic [CW-1:0] cnt_din = '0;
    logic [AW-1:0] src_din = '0, dst_din = '0;
    logic [PW-1:0] op_pc = '0;
    logic irq_take, done, busy, mem_req, mem_we;
    logic [PW-1:0] ret_pc;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q, dst_q, mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [DW-1:0] mem [MSZ];
    logic [DW-1:0] gold [MSZ];

    int n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
    // behavioural reference: phase 0 idle, 1 boundary, 2 read, 3 write
    int m_ph = 0, m_cnt = 0, m_src = 0, m_dst = 0, m_pc = 0, m_dat = 0;

    always #2.5 clk = ~clk;
    assign mem_rdata = mem[mem_addr];

    rep_move_seq #(.AW(AW), .DW(DW), .CW(CW), .PW(PW)) u0 (
        .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .cnt_din(cnt_din), .ptr_wr(ptr_wr),
        .src_din(src_din), .dst_din(dst_din), .go(go), .op_pc(op_pc), .irq_req(irq_req),
        .irq_take(irq_take), .done(done), .ret_pc(ret_pc), .busy(busy), .cnt_q(cnt_q),
        .src_q(src_q), .dst_q(dst_q), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready));

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_src = 0; m_dst = 0; m_pc = 0;
        end else begin
            case (m_ph)
                0: begin
                    if (cnt_wr) m_cnt = int'(cnt_din);
                    if (ptr_wr) begin m_src = int'(src_din); m_dst = int'(dst_din); end
                    if (go) begin m_pc = int'(op_pc); m_ph = 1; end
                end
                1: m_ph = (m_cnt == 0 || irq_req) ? 0 : 2;
                2: if (mem_ready) begin m_dat = int'(mem[m_src]); m_ph = 3; end
                default: if (mem_ready) begin
                    m_cnt = (m_cnt - 1) & (2**CW - 1);
                    m_src = (m_src + 1) % MSZ;
                    m_dst = (m_dst + 1) % MSZ;
                    m_ph = 1;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 busy", int'(busy), int'(m_ph != 0));
        chk("R2 cnt_q", int'(cnt_q), m_cnt);
        chk("R3 src_q", int'(src_q), m_src);
        chk("R3 dst_q", int'(dst_q), m_dst);
        chk("R4 mem_req", int'(mem_req), int'(m_ph >= 2));
        chk("R6 done", int'(done), int'(m_ph == 1 && m_cnt == 0));
        chk("R7 irq_take", int'(irq_take), int'(m_ph == 1 && m_cnt != 0 && irq_req));
        if (m_ph >= 2) begin
            chk("R3 mem_we", int'(mem_we), int'(m_ph == 3));
            chk("R3 mem_addr", int'(mem_addr), m_ph == 3 ? m_dst : m_src);
        end
        if (m_ph == 3) chk("R3 wdata", int'(mem_wdata), m_dat);
        if (m_ph == 1 && m_cnt == 0) chk("R6 ret_pc", int'(ret_pc), (m_pc + 2) % (2**PW));
        if (m_ph == 1 && m_cnt != 0 && irq_req) chk("R7 ret_pc", int'(ret_pc), m_pc);
    endtask

    task automatic step();
        @(negedge clk);
        mem_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 1);
        cyc++;
        #1;
        compare();
        if (mem_req && mem_we && mem_ready) mem[mem_addr] = mem_wdata;
    endtask

    task automatic setup(input int c, input int s, input int d);
        cnt_wr = 1; cnt_din = CW'(c); ptr_wr = 1; src_din = AW'(s); dst_din = AW'(d);
        step();
        cnt_wr = 0; ptr_wr = 0;
        for (int i = 0; i < c; i++) gold[(d + i) % MSZ] = gold[(s + i) % MSZ];
    endtask

    task automatic issue(input int pc);
        op_pc = PW'(pc); go = 1; step(); go = 0;
    endtask

    task automatic run_idle(input string tag);
        int k = 0;
        step();
        while (busy && k < 2000) begin step(); k++; end
        if (k >= 2000) chk({tag, " watchdog"}, 1, 0);
    endtask

    task automatic mem_match(input string tag);
        int bad = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== gold[i]) bad++;
        chk(tag, bad, 0);
    endtask

    initial begin
        int snap;
        for (int i = 0; i < MSZ; i++) begin mem[i] = DW'(i * 37 + 5); gold[i] = DW'(i * 37 + 5); end
        fork
            begin #900000; chk("watchdog", 1, 0); $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad); $finish; end
        join_none
        step(); step();
        rst = 0;
        step();
        chk("R1 reset idle", int'(busy || mem_req || done || irq_take), 0);
        chk("R1 reset cnt", int'(cnt_q), 0);

        // plain copy, memory always ready
        setup(5, 10, 30);
        issue(100);
        run_idle("R6 copy");
        chk("R6 count exhausted", int'(cnt_q), 0);
        mem_match("R3 plain copy memory");

        // zero count: immediate completion, no access
        setup(0, 50, 60);
        issue(200);
        chk("R5 done after go", int'(done), 1);
        chk("R5 no request", int'(mem_req), 0);
        chk("R5 ret_pc", int'(ret_pc), 202);
        step();
        chk("R5 idle again", int'(busy), 0);

        // zero count with interrupt held: completion wins
        irq_req = 1;
        issue(300);
        chk("R10 done wins", int'(done), 1);
        chk("R10 no take", int'(irq_take), 0);
        step();
        irq_req = 0;

        // overlapped copy with stalls, interrupt raised mid read, resumed
        rdy_mode = 1;
        setup(8, 40, 42);
        issue(400);
        step(); step();
        while (!(mem_req && !mem_we)) step();
        snap = int'(cnt_q);
        irq_req = 1;
        // writes to architectural registers while busy must be ignored
        cnt_wr = 1; cnt_din = 8'd99; ptr_wr = 1; src_din = 8'd1; dst_din = 8'd2;
        step();
        cnt_wr = 0; ptr_wr = 0;
        chk("R2 load ignored cnt", int'(cnt_q), snap);
        run_idle("R8 take");
        irq_req = 0;
        chk("R8 one iteration finished", int'(cnt_q), snap - 1);
        chk("R7 kept pointers", int'(src_q), 40 + 8 - (snap - 1));
        step();
        issue(400);
        run_idle("R9 resume");
        mem_match("R9 overlap resume memory");

        // interrupt pending at go: taken before any move
        rdy_mode = 0;
        setup(3, 90, 120);
        irq_req = 1;
        issue(500);
        chk("R7 take at first boundary", int'(irq_take), 1);
        chk("R7 ret_pc is repeat op", int'(ret_pc), 500);
        step();
        irq_req = 0;
        chk("R7 count kept", int'(cnt_q), 3);
        issue(500);
        run_idle("R9 second resume");
        mem_match("R9 resumed memory");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule